// File: doc/BRIEF.md
# Shared Free Buffer Manager

This block keeps track of which fixed-size packet storage blocks are free in a two-port store-and-forward switch. Both ports draw from a single pool. When a port's receive buffer logic needs room for an incoming frame, it raises an allocate request and receives a block index from the pool. When a stored frame has been sent out of the other port, the transmit side hands the index back through a release strobe.

The free indices sit in a first-in first-out list, so blocks are reused in the order they were freed. A round-robin arbiter decides which port is served when both ask in the same cycle. A free-map guard rejects a release of an index that is already free. A rejected release leaves the pool unchanged and sets a sticky error flag. The frame memory itself, the MAC logic and the address lookup sit outside this block.

Top module: `fbm_pool`

## Requirements
- R1: After reset every block is free. `pool_empty` and `dbl_free_err` are 0. With no releases in between, successive grants hand out indices 0, 1, 2 and so on in ascending order.
- R2: While the pool is not empty, a pending request is granted in the same cycle. `alloc_gnt[p]` is high for one cycle. `alloc_idx[p*5 +: 5]` carries the index, which is the oldest free index.
- R3: When both ports request in the same cycle, exactly one is granted. The port granted is the one other than the port that received the most recent grant. Port 0 goes first after reset.
- R4: After the last free block is granted, `pool_empty` is 1. Requests made while the pool is empty stay ungranted, and `alloc_gnt` stays 0.
- R5: An accepted release adds its index behind all indices that are already free. When both ports release in the same cycle, the port 0 index goes in before the port 1 index.
- R6: A release and an allocation in the same cycle both take effect. A released index is granted no earlier than the cycle after its release, even when a request is waiting on an empty pool.
- R7: A release of an index that is currently free sets `dbl_free_err` from the next cycle on, and the flag stays set until reset. The pool contents are unchanged, so the same number of grants is possible before `pool_empty` rises. A second release of the same index in one cycle counts as such a duplicate.
- R8: A grant goes only to a port whose request is high, and at most one port is granted per cycle.
- R9: An index that has been granted is not granted again until it has been released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| alloc_req | input | NPORTS | Per-port request for a free block, held until granted |
| alloc_gnt | output | NPORTS | Per-port grant, high for one cycle |
| alloc_idx | output | NPORTS*5 | Per-port granted index, port p at bits [p*5 +: 5] |
| rel_vld | input | NPORTS | Per-port release strobe |
| rel_idx | input | NPORTS*5 | Per-port index being returned, port p at bits [p*5 +: 5] |
| pool_empty | output | 1 | No free block remains |
| dbl_free_err | output | 1 | Sticky flag set by the release of an already free index |

## Verification
Grants, granted indices and `pool_empty` are combinational from the request and the registered pool state. The bench therefore drives inputs at the falling edge and reads these outputs 1 ns later, in the same cycle. A release or grant changes the pool at the next rising edge. A released index, and `dbl_free_err` after a duplicate release, are expected one cycle after the stimulus and are checked at the next falling edge. The bench keeps its own free queue, free map and round-robin pointer, and uses them to predict every grant, index, empty flag and error value for each cycle.

// File: rtl/fbm_pkg.sv
package fbm_pkg;
  localparam int unsigned FBM_NBLK   = 32;
  localparam int unsigned FBM_NPORTS = 2;

  // Number of set bits in a request/strobe vector
  function automatic int unsigned fbm_popcnt(input logic [FBM_NPORTS-1:0] v);
    int unsigned n;
    n = 0;
    for (int i = 0; i < int'(FBM_NPORTS); i++) n += int'(v[i]);
    return n;
  endfunction
endpackage

// File: rtl/fbm_rr_arb.sv
module fbm_rr_arb #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  localparam int unsigned PW = (N > 1) ? $clog2(N) : 1;

  logic [PW-1:0] last_q, last_d;
  logic          found;
  int unsigned   cand;

  always_comb begin
    gnt    = '0;
    last_d = last_q;
    found  = 1'b0;
    cand   = 0;
    for (int unsigned k = 1; k <= N; k++) begin
      cand = (int'(last_q) + k) % N;
      if (en && !found && req[cand]) begin
        gnt[cand] = 1'b1;
        last_d    = PW'(cand);
        found     = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     last_q <= PW'(N - 1);
    else if (found) last_q <= last_d;
  end
endmodule

// File: rtl/fbm_free_fifo.sv
module fbm_free_fifo #(
  parameter int unsigned NBLK  = 32,
  parameter int unsigned NPUSH = 2,
  localparam int unsigned IW   = $clog2(NBLK),
  localparam int unsigned CW   = $clog2(NBLK + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pop,
  input  logic [NPUSH-1:0]    push_vld,
  input  logic [NPUSH*IW-1:0] push_idx,
  output logic [IW-1:0]       head,
  output logic [CW-1:0]       count
);
  logic [IW-1:0] mem_q [NBLK];
  logic [IW-1:0] mem_d [NBLK];
  logic [IW-1:0] rd_q, rd_d, wr_q, wr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          upd;

  always_comb begin
    mem_d = mem_q;
    wr_d  = wr_q;
    cnt_d = cnt_q;
    for (int unsigned p = 0; p < NPUSH; p++) begin
      if (push_vld[p]) begin
        mem_d[wr_d] = push_idx[p*IW +: IW];
        wr_d        = wr_d + IW'(1);
        cnt_d       = cnt_d + CW'(1);
      end
    end
    rd_d = rd_q;
    if (pop) begin
      rd_d  = rd_q + IW'(1);
      cnt_d = cnt_d - CW'(1);
    end
    upd = pop || (|push_vld);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int unsigned i = 0; i < NBLK; i++) mem_q[i] <= IW'(i);
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= CW'(NBLK);
    end else if (upd) begin
      mem_q <= mem_d;
      rd_q  <= rd_d;
      wr_q  <= wr_d;
      cnt_q <= cnt_d;
    end
  end

  assign head  = mem_q[rd_q];
  assign count = cnt_q;
endmodule

// File: rtl/fbm_dup_guard.sv
module fbm_dup_guard #(
  parameter int unsigned NBLK   = 32,
  parameter int unsigned NPORTS = 2,
  localparam int unsigned IW    = $clog2(NBLK)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NPORTS-1:0]    rel_vld,
  input  logic [NPORTS*IW-1:0] rel_idx,
  input  logic                 take,
  input  logic [IW-1:0]        take_idx,
  output logic [NPORTS-1:0]    acc_vld,
  output logic                 err
);
  logic [NBLK-1:0] map_q, map_d;
  logic            dup, err_q;

  always_comb begin
    map_d   = map_q;
    acc_vld = '0;
    dup     = 1'b0;
    for (int unsigned p = 0; p < NPORTS; p++) begin
      if (rel_vld[p]) begin
        if (map_d[rel_idx[p*IW +: IW]]) begin
          dup = 1'b1;
        end else begin
          map_d[rel_idx[p*IW +: IW]] = 1'b1;
          acc_vld[p]                 = 1'b1;
        end
      end
    end
    if (take) map_d[take_idx] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      map_q <= '1;
    else if (take || (|rel_vld))     map_q <= map_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   err_q <= 1'b0;
    else if (dup) err_q <= 1'b1;
  end

  assign err = err_q;
endmodule

// File: rtl/fbm_pool.sv
module fbm_pool #(
  parameter int unsigned NBLK   = fbm_pkg::FBM_NBLK,
  parameter int unsigned NPORTS = fbm_pkg::FBM_NPORTS,
  localparam int unsigned IW    = $clog2(NBLK),
  localparam int unsigned CW    = $clog2(NBLK + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NPORTS-1:0]    alloc_req,
  output logic [NPORTS-1:0]    alloc_gnt,
  output logic [NPORTS*IW-1:0] alloc_idx,
  input  logic [NPORTS-1:0]    rel_vld,
  input  logic [NPORTS*IW-1:0] rel_idx,
  output logic                 pool_empty,
  output logic                 dbl_free_err
);
  logic [1:0]        rst_sync;
  logic              rst_int_n;
  logic [IW-1:0]     head;
  logic [CW-1:0]     count;
  logic [NPORTS-1:0] acc_vld;
  logic              take;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  assign pool_empty = (count == '0);
  assign take       = |alloc_gnt;

  fbm_rr_arb #(.N(NPORTS)) u_arb (
    .clk   (clk),
    .rst_n (rst_int_n),
    .en    (!pool_empty),
    .req   (alloc_req),
    .gnt   (alloc_gnt)
  );

  fbm_dup_guard #(.NBLK(NBLK), .NPORTS(NPORTS)) u_guard (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .rel_vld  (rel_vld),
    .rel_idx  (rel_idx),
    .take     (take),
    .take_idx (head),
    .acc_vld  (acc_vld),
    .err      (dbl_free_err)
  );

  fbm_free_fifo #(.NBLK(NBLK), .NPUSH(NPORTS)) u_fifo (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .pop      (take),
    .push_vld (acc_vld),
    .push_idx (rel_idx),
    .head     (head),
    .count    (count)
  );

  for (genvar p = 0; p < NPORTS; p++) begin : g_idx
    assign alloc_idx[p*IW +: IW] = head;
  end
endmodule

// File: rtl/fbm_pool_chk.sv
module fbm_pool_chk #(
  parameter int unsigned NPORTS = 2,
  parameter int unsigned IW     = 5
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NPORTS-1:0]    alloc_req,
  input logic [NPORTS-1:0]    alloc_gnt,
  input logic                 pool_empty,
  input logic                 dbl_free_err
);
  // R8
  gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(alloc_gnt));

  // R8
  gnt_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_gnt & ~alloc_req) == '0);

  // R4
  empty_no_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pool_empty |-> (alloc_gnt == '0));

  // R2
  serve_when_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|alloc_req) && !pool_empty) |-> (|alloc_gnt));

  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dbl_free_err |=> dbl_free_err);

  // R3
  rr_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(alloc_gnt[0] && alloc_req[1]) && alloc_req[0] && alloc_req[1] && !pool_empty)
      |-> alloc_gnt[1]);
endmodule

bind fbm_pool fbm_pool_chk #(.NPORTS(NPORTS), .IW(IW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .alloc_req    (alloc_req),
  .alloc_gnt    (alloc_gnt),
  .pool_empty   (pool_empty),
  .dbl_free_err (dbl_free_err)
);

// File: tb/fbm_pool_bench.sv
module fbm_pool_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 32;

  logic       clk;
  logic       rst_n;
  logic [1:0] alloc_req;
  logic [1:0] alloc_gnt;
  logic [9:0] alloc_idx;
  logic [1:0] rel_vld;
  logic [9:0] rel_idx;
  logic       pool_empty;
  logic       dbl_free_err;

  int n_chk;
  int n_err;
  int q[$];
  bit fmap[NB];
  int lg;
  bit exp_err;
  bit done;

  fbm_pool u_fbm_pool (
    .clk (clk), .rst_n (rst_n),
    .alloc_req (alloc_req), .alloc_gnt (alloc_gnt), .alloc_idx (alloc_idx),
    .rel_vld (rel_vld), .rel_idx (rel_idx),
    .pool_empty (pool_empty), .dbl_free_err (dbl_free_err)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // One cycle: drive at falling edge, check 1 ns later, update model
  task automatic cyc(input logic [1:0] req, input logic [1:0] rv,
                     input int ri0, input int ri1, input string tag);
    logic [1:0] eg;
    int p;
    int ei;
    @(negedge clk);
    alloc_req = req;
    rel_vld   = rv;
    rel_idx   = {5'(ri1), 5'(ri0)};
    #1;
    eg = 2'b00;
    if (q.size() > 0 && req != 2'b00) begin
      if (req == 2'b11) eg = (lg == 0) ? 2'b10 : 2'b01;
      else              eg = req;
    end
    chk(tag, "gnt", int'(alloc_gnt), int'(eg));
    chk(tag, "empty", int'(pool_empty), int'(q.size() == 0));
    chk(tag, "err", int'(dbl_free_err), int'(exp_err));
    if (eg != 2'b00) begin
      p  = eg[1] ? 1 : 0;
      ei = q.pop_front();
      chk(tag, "idx", int'(alloc_idx[p*5 +: 5]), ei);
      // R9: granted index must not be already held
      chk("R9", "held-before-grant", int'(!fmap[ei]), 0);
      fmap[ei] = 1'b0;
      lg = p;
    end
    for (int r = 0; r < 2; r++) begin
      if (rv[r]) begin
        ei = (r == 0) ? ri0 : ri1;
        if (fmap[ei]) exp_err = 1'b1;
        else begin fmap[ei] = 1'b1; q.push_back(ei); end
      end
    end
  endtask

  task automatic idle(input string tag);
    cyc(2'b00, 2'b00, 0, 0, tag);
  endtask

  task automatic t_reset;
    alloc_req = '0; rel_vld = '0; rel_idx = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    q.delete();
    for (int i = 0; i < NB; i++) begin q.push_back(i); fmap[i] = 1'b1; end
    lg = 1; exp_err = 1'b0;
    repeat (3) @(posedge clk);
    idle("R1");
  endtask

  task automatic t_single;
    cyc(2'b01, 2'b00, 0, 0, "R1 R2 R8");   // index 0 to port 0
    cyc(2'b10, 2'b00, 0, 0, "R1 R2 R8");   // index 1 to port 1
    cyc(2'b10, 2'b00, 0, 0, "R2 R8");      // port 1 again alone
  endtask

  task automatic t_both;
    for (int i = 0; i < 5; i++) cyc(2'b11, 2'b00, 0, 0, "R3");
  endtask

  task automatic t_drain;
    while (q.size() > 0) cyc(2'b01, 2'b00, 0, 0, "R4");
    cyc(2'b01, 2'b00, 0, 0, "R4");
    cyc(2'b11, 2'b00, 0, 0, "R4");
  endtask

  task automatic t_rel_empty;
    cyc(2'b10, 2'b01, 7, 0, "R6");    // no grant in release cycle
    cyc(2'b10, 2'b00, 0, 0, "R6");    // index 7 granted next cycle
    idle("R6");
  endtask

  task automatic t_rel_order;
    cyc(2'b00, 2'b11, 12, 4, "R5");
    cyc(2'b00, 2'b01, 9, 0, "R5");
    cyc(2'b01, 2'b00, 0, 0, "R5");    // expect 12
    cyc(2'b10, 2'b00, 0, 0, "R5");    // expect 4
  endtask

  task automatic t_rel_alloc;
    cyc(2'b01, 2'b10, 0, 2, "R6");    // 9 granted, 2 returned
    cyc(2'b01, 2'b01, 3, 0, "R6");    // 2 granted, 3 returned
    cyc(2'b10, 2'b00, 0, 0, "R6");    // 3 granted
    idle("R6");
  endtask

  task automatic t_dup;
    cyc(2'b00, 2'b01, 5, 0, "R7");
    cyc(2'b00, 2'b10, 0, 5, "R7");    // 5 already free
    idle("R7");
    cyc(2'b00, 2'b11, 6, 6, "R7");    // same index twice
    idle("R7");
    while (q.size() > 0) cyc(2'b10, 2'b00, 0, 0, "R7");
    cyc(2'b11, 2'b00, 0, 0, "R7");
    idle("R7");
  endtask

  initial begin
    n_chk = 0; n_err = 0; done = 1'b0;
    t_reset();
    t_single();
    t_both();
    t_drain();
    t_rel_empty();
    t_rel_order();
    t_rel_alloc();
    t_dup();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog run did not finish actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule